// File: doc/BRIEF.md
# Prescaled 16-bit Register Timer

This block is a general-purpose timer peripheral that software drives through a simple synchronous register bus. A write strobe, an address and a write word update the registers on the clock edge. The read word is a pure combinational function of the address and the current register state. A power-of-two prescaler divides the peripheral clock. Each terminal count of the prescaler moves a 16-bit counter one step.

The counter has two directions. Counting up, it gives a free-running timebase that wraps from the top value back to zero. Counting down, it produces a periodic event by reloading from the top register on underflow, or a single event when one-shot is enabled, after which it halts by itself. Two event flags record wrap and underflow. Software can set or clear these flags through dedicated write-one registers, and an enable mask selects which flags drive the single interrupt output.

Top module: `tmr16_top`

## Requirements
- R1: After reset every register reads 0, except the top register, which reads 0x0000FFFF. The interrupt output is low.
- R2: The control word at 0x00 keeps prescale select in bits 27:24, clock select in bits 17:16, one-shot in bit 4 and direction in bits 1:0, and reads back with all other bits 0. The top register (0x1C), counter (0x24) and enable mask (0x0C) read back the low 16 or 2 bits written. Command (0x04) and the flag set/clear registers read 0.
- R3: A write to 0x04 with bit 0 set starts the counter, and with bit 1 set stops it. Stop wins if both are set. A stopped counter holds its value.
- R4: The counter moves only on prescaler terminal counts, once every 2^P clocks for prescale select P. The first step comes 2^P clocks after the start write, because a start write restarts the prescaler.
- R5: With direction value 0 the counter counts up. A step taken at the top value wraps it to 0 and sets flag bit 0.
- R6: With direction value 1 and one-shot clear, a step taken at 0 reloads the top value, sets flag bit 1, and keeps the counter running.
- R7: With direction value 1 and one-shot set, a step taken at 0 sets flag bit 1, leaves the counter at 0 and stops it.
- R8: The flag register (0x10) holds wrap in bit 0 and underflow in bit 1. Writing ones to 0x14 sets the matching flags, and writing ones to 0x18 clears them. A hardware event in the same cycle as a software clear leaves the flag set.
- R9: The interrupt output is high exactly when some flag bit and its enable bit (0x0C) are both 1.
- R10: A write to the counter register loads the value on the next edge. The load overrides any step due in that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Peripheral clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 8 | Register byte offset |
| reg_wdata | input | 32 | Register write word |
| reg_rdata | output | 32 | Register read word for reg_addr |
| irq | output | 1 | Interrupt request |

## Verification
The counter is run up from zero with no prescaling and with divide-by-8. Matching the step count with and without the divider separates a correct terminal-count mask from an off-by-one divider. A stop and immediate restart in the middle of a divide-by-4 period shows whether the start command really clears the prescaler phase. Up-wrap at a small top, periodic down-count and one-shot down-count are each run across the zero or top boundary: the reloaded value, a zero that holds, or a counter that keeps moving after the boundary tell the three behaviours apart. The flag tests pair a software clear with an underflow on the same edge, and walk the enable mask against single flags to isolate each interrupt term.

// File: rtl/tmr_pkg.sv
`timescale 1ns/1ps
package tmr_pkg;
  localparam int unsigned REG_AW = 8;
  localparam int unsigned REG_DW = 32;

  localparam logic [REG_AW-1:0] A_CTRL = 8'h00;
  localparam logic [REG_AW-1:0] A_CMD  = 8'h04;
  localparam logic [REG_AW-1:0] A_IEN  = 8'h0C;
  localparam logic [REG_AW-1:0] A_FLAG = 8'h10;
  localparam logic [REG_AW-1:0] A_FSET = 8'h14;
  localparam logic [REG_AW-1:0] A_FCLR = 8'h18;
  localparam logic [REG_AW-1:0] A_TOP  = 8'h1C;
  localparam logic [REG_AW-1:0] A_CNT  = 8'h24;

  localparam int unsigned F_PRESC_LSB  = 24;
  localparam int unsigned F_PRESC_W    = 4;
  localparam int unsigned F_CLKSEL_LSB = 16;
  localparam int unsigned F_CLKSEL_W   = 2;
  localparam int unsigned F_ONESHOT    = 4;
  localparam int unsigned F_MODE_LSB   = 0;
  localparam int unsigned F_MODE_W     = 2;

  localparam int unsigned CMD_GO   = 0;
  localparam int unsigned CMD_HALT = 1;

  localparam int unsigned FLAG_W   = 2;
  localparam int unsigned FLAG_OVF = 0;
  localparam int unsigned FLAG_UNF = 1;

  typedef enum logic [F_MODE_W-1:0] {
    MODE_UP   = 2'd0,
    MODE_DOWN = 2'd1,
    MODE_RS2  = 2'd2,
    MODE_RS3  = 2'd3
  } mode_e;

  typedef struct packed {
    logic [F_PRESC_W-1:0]  presc;
    logic [F_CLKSEL_W-1:0] clksel;
    logic                  one_shot;
    mode_e                 mode;
  } ctrl_t;

  function automatic ctrl_t ctrl_unpack(input logic [REG_DW-1:0] w);
    ctrl_t c;
    c.presc    = w[F_PRESC_LSB +: F_PRESC_W];
    c.clksel   = w[F_CLKSEL_LSB +: F_CLKSEL_W];
    c.one_shot = w[F_ONESHOT];
    c.mode     = mode_e'(w[F_MODE_LSB +: F_MODE_W]);
    return c;
  endfunction

  function automatic logic [REG_DW-1:0] ctrl_pack(input ctrl_t c);
    logic [REG_DW-1:0] w;
    w = '0;
    w[F_PRESC_LSB +: F_PRESC_W]   = c.presc;
    w[F_CLKSEL_LSB +: F_CLKSEL_W] = c.clksel;
    w[F_ONESHOT]                  = c.one_shot;
    w[F_MODE_LSB +: F_MODE_W]     = c.mode;
    return w;
  endfunction
endpackage

// File: rtl/tmr_prescaler.sv
`timescale 1ns/1ps
module tmr_prescaler #(
  parameter int unsigned SEL_W = 4,
  parameter int unsigned PS_W  = 15
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic             restart,
  input  logic [SEL_W-1:0] sel,
  output logic             tick
);
  logic [PS_W-1:0] pcnt_q;

  // Low 'sel' bits set: terminal count is reached when they are all ones.
  function automatic logic [PS_W-1:0] div_mask(input logic [SEL_W-1:0] s);
    logic [PS_W-1:0] m;
    for (int i = 0; i < PS_W; i++) m[i] = (i < int'(s));
    return m;
  endfunction

  always_ff @(posedge clk) begin
    if (!rst_n)       pcnt_q <= '0;
    else if (restart) pcnt_q <= '0;
    else if (run)     pcnt_q <= pcnt_q + 1'b1;
  end

  assign tick = run && !restart && ((pcnt_q | ~div_mask(sel)) == '1);
endmodule

// File: rtl/tmr_counter.sv
`timescale 1ns/1ps
module tmr_counter #(
  parameter int unsigned CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             step,
  input  logic             down,
  input  logic             one_shot,
  input  logic [CNT_W-1:0] top,
  input  logic             ld_en,
  input  logic [CNT_W-1:0] ld_val,
  output logic [CNT_W-1:0] cnt,
  output logic             ovf_evt,
  output logic             uf_evt
);
  logic [CNT_W-1:0] cnt_q;
  logic             step_ok;

  function automatic logic [CNT_W-1:0] up_next(input logic [CNT_W-1:0] c,
                                               input logic [CNT_W-1:0] t);
    return (c == t) ? '0 : c + 1'b1;
  endfunction

  function automatic logic [CNT_W-1:0] down_next(input logic [CNT_W-1:0] c,
                                                 input logic [CNT_W-1:0] t,
                                                 input logic            os);
    if (c == '0) return os ? '0 : t;
    return c - 1'b1;
  endfunction

  // A software load cancels the step of the same cycle.
  assign step_ok = step && !ld_en;
  assign ovf_evt = step_ok && !down && (cnt_q == top);
  assign uf_evt  = step_ok &&  down && (cnt_q == '0);

  always_ff @(posedge clk) begin
    if (!rst_n)       cnt_q <= '0;
    else if (ld_en)   cnt_q <= ld_val;
    else if (step_ok) cnt_q <= down ? down_next(cnt_q, top, one_shot)
                                    : up_next(cnt_q, top);
  end

  assign cnt = cnt_q;
endmodule

// File: rtl/tmr_flags.sv
`timescale 1ns/1ps
module tmr_flags #(
  parameter int unsigned FW = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [FW-1:0] hw_set,
  input  logic [FW-1:0] sw_set,
  input  logic [FW-1:0] sw_clr,
  input  logic [FW-1:0] ien,
  output logic [FW-1:0] flags,
  output logic          irq
);
  logic [FW-1:0] flags_q;

  // Any set source dominates a clear in the same cycle.
  function automatic logic flag_next(input logic cur, input logic hs,
                                     input logic ss, input logic sc);
    return (cur && !sc) || ss || hs;
  endfunction

  for (genvar b = 0; b < FW; b++) begin : g_flag
    always_ff @(posedge clk) begin
      if (!rst_n) flags_q[b] <= 1'b0;
      else        flags_q[b] <= flag_next(flags_q[b], hw_set[b], sw_set[b], sw_clr[b]);
    end
  end

  assign flags = flags_q;
  assign irq   = |(flags_q & ien);
endmodule

// File: rtl/tmr16_top.sv
`timescale 1ns/1ps
module tmr16_top import tmr_pkg::*; #(
  parameter int unsigned CNT_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_we,
  input  logic [REG_AW-1:0] reg_addr,
  input  logic [REG_DW-1:0] reg_wdata,
  output logic [REG_DW-1:0] reg_rdata,
  output logic              irq
);
  localparam int unsigned PS_W = (1 << F_PRESC_W) - 1;

  ctrl_t             ctrl_q;
  logic [CNT_W-1:0]  top_q;
  logic [FLAG_W-1:0] ien_q;
  logic              running_q;

  logic ctrl_wr, cmd_wr, ien_wr, fset_wr, fclr_wr, top_wr, cnt_wr;
  logic start_cmd, stop_cmd;
  logic tick, ovf_evt, uf_evt, down;
  logic [CNT_W-1:0]  cnt_q;
  logic [FLAG_W-1:0] flags_q, hw_set, sw_set, sw_clr;
  logic              unused_wdata_bits;

  assign ctrl_wr = reg_we && (reg_addr == A_CTRL);
  assign cmd_wr  = reg_we && (reg_addr == A_CMD);
  assign ien_wr  = reg_we && (reg_addr == A_IEN);
  assign fset_wr = reg_we && (reg_addr == A_FSET);
  assign fclr_wr = reg_we && (reg_addr == A_FCLR);
  assign top_wr  = reg_we && (reg_addr == A_TOP);
  assign cnt_wr  = reg_we && (reg_addr == A_CNT);

  assign start_cmd = cmd_wr && reg_wdata[CMD_GO];
  assign stop_cmd  = cmd_wr && reg_wdata[CMD_HALT];
  assign down      = (ctrl_q.mode == MODE_DOWN);

  assign unused_wdata_bits = &{1'b0, reg_wdata};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ctrl_q <= '0;
      top_q  <= '1;
      ien_q  <= '0;
    end else begin
      if (ctrl_wr) ctrl_q <= ctrl_unpack(reg_wdata);
      if (top_wr)  top_q  <= reg_wdata[CNT_W-1:0];
      if (ien_wr)  ien_q  <= reg_wdata[FLAG_W-1:0];
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n)                          running_q <= 1'b0;
    else if (stop_cmd)                   running_q <= 1'b0;
    else if (start_cmd)                  running_q <= 1'b1;
    else if (uf_evt && ctrl_q.one_shot)  running_q <= 1'b0;
  end

  tmr_prescaler #(.SEL_W(F_PRESC_W), .PS_W(PS_W)) i_presc (
    .clk     (clk),
    .rst_n   (rst_n),
    .run     (running_q),
    .restart (start_cmd),
    .sel     (ctrl_q.presc),
    .tick    (tick)
  );

  tmr_counter #(.CNT_W(CNT_W)) i_cnt (
    .clk      (clk),
    .rst_n    (rst_n),
    .step     (tick),
    .down     (down),
    .one_shot (ctrl_q.one_shot),
    .top      (top_q),
    .ld_en    (cnt_wr),
    .ld_val   (reg_wdata[CNT_W-1:0]),
    .cnt      (cnt_q),
    .ovf_evt  (ovf_evt),
    .uf_evt   (uf_evt)
  );

  always_comb begin
    hw_set           = '0;
    hw_set[FLAG_OVF] = ovf_evt;
    hw_set[FLAG_UNF] = uf_evt;
  end

  assign sw_set = fset_wr ? reg_wdata[FLAG_W-1:0] : '0;
  assign sw_clr = fclr_wr ? reg_wdata[FLAG_W-1:0] : '0;

  tmr_flags #(.FW(FLAG_W)) i_flags (
    .clk    (clk),
    .rst_n  (rst_n),
    .hw_set (hw_set),
    .sw_set (sw_set),
    .sw_clr (sw_clr),
    .ien    (ien_q),
    .flags  (flags_q),
    .irq    (irq)
  );

  always_comb begin
    case (reg_addr)
      A_CTRL:  reg_rdata = ctrl_pack(ctrl_q);
      A_IEN:   reg_rdata = REG_DW'(ien_q);
      A_FLAG:  reg_rdata = REG_DW'(flags_q);
      A_TOP:   reg_rdata = REG_DW'(top_q);
      A_CNT:   reg_rdata = REG_DW'(cnt_q);
      default: reg_rdata = '0;
    endcase
  end
endmodule

// File: rtl/tmr16_chk.sv
`timescale 1ns/1ps
module tmr16_chk #(
  parameter int unsigned CNT_W = 16,
  parameter int unsigned FW    = 2,
  parameter int unsigned SEL_W = 4
) (
  input logic             clk,
  input logic             rst_n,
  input logic             irq,
  input logic             running_q,
  input logic             start_cmd,
  input logic             stop_cmd,
  input logic             cnt_wr,
  input logic             tick,
  input logic             ovf_evt,
  input logic             uf_evt,
  input logic             one_shot,
  input logic [SEL_W-1:0] presc,
  input logic [CNT_W-1:0] cnt_q,
  input logic [CNT_W-1:0] top_q,
  input logic [FW-1:0]    flags_q,
  input logic [FW-1:0]    ien_q
);
  // R3
  stopped_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!running_q && !start_cmd && !cnt_wr) |=> $stable(cnt_q));

  // R4
  presc_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (start_cmd && !stop_cmd && presc != '0) |=> !tick);

  // R5
  up_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ovf_evt |=> (cnt_q == '0) && flags_q[0]);

  // R6
  down_reload_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (uf_evt && !one_shot) |=> (cnt_q == $past(top_q)) && flags_q[1]);

  // R7
  oneshot_halt_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (uf_evt && one_shot && !start_cmd) |=> !running_q && (cnt_q == '0));

  // R8
  unf_set_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    uf_evt |=> flags_q[1]);

  // R9
  irq_masked_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ien_q == '0) |-> !irq);
endmodule

bind tmr16_top tmr16_chk #(.CNT_W(CNT_W), .FW(tmr_pkg::FLAG_W), .SEL_W(tmr_pkg::F_PRESC_W)) i_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .irq       (irq),
  .running_q (running_q),
  .start_cmd (start_cmd),
  .stop_cmd  (stop_cmd),
  .cnt_wr    (cnt_wr),
  .tick      (tick),
  .ovf_evt   (ovf_evt),
  .uf_evt    (uf_evt),
  .one_shot  (ctrl_q.one_shot),
  .presc     (ctrl_q.presc),
  .cnt_q     (cnt_q),
  .top_q     (top_q),
  .flags_q   (flags_q),
  .ien_q     (ien_q)
);

// File: tb/test_tmr16_top.sv
`timescale 1ns/1ps
module test_tmr16_top;
  localparam logic [7:0] R_CTRL = 8'h00, R_CMD = 8'h04, R_IEN = 8'h0C, R_FLAG = 8'h10,
                         R_FSET = 8'h14, R_FCLR = 8'h18, R_TOP = 8'h1C, R_CNT = 8'h24;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_we = 1'b0;
  logic [7:0]  reg_addr = 8'h00;
  logic [31:0] reg_wdata = 32'h0;
  logic [31:0] reg_rdata;
  logic        irq;

  int n_checks = 0;
  int n_fail   = 0;
  bit done     = 1'b0;

  logic [31:0] exp_q[$];
  bit          kind_q[$];
  string       tag_q[$];
  logic [31:0] m_exp, m_act;
  bit          m_kind;
  string       m_tag;

  always #4 clk = ~clk;

  tmr16_top i_tmr16_top (
    .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq(irq)
  );

  // Expected up-count: one step per 2^p clocks after start, wrap past top.
  function automatic int up_expect(int init, int k, int p, int topv);
    return (init + k / (1 << p)) % (topv + 1);
  endfunction

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic expect_reg(input logic [7:0] a, input logic [31:0] e, input string tag);
    reg_addr = a;
    exp_q.push_back(e); kind_q.push_back(1'b0); tag_q.push_back(tag);
    @(negedge clk);
  endtask

  task automatic expect_irq(input logic e, input string tag);
    exp_q.push_back({31'b0, e}); kind_q.push_back(1'b1); tag_q.push_back(tag);
    @(negedge clk);
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  // Monitor: compares queued expectations against the ports.
  initial begin
    forever begin
      @(negedge clk);
      #1;
      while (exp_q.size() != 0) begin
        m_exp  = exp_q.pop_front();
        m_kind = kind_q.pop_front();
        m_tag  = tag_q.pop_front();
        m_act  = m_kind ? {31'b0, irq} : reg_rdata;
        n_checks++;
        if (m_act !== m_exp) begin
          n_fail++;
          $display("FAIL %s actual=%h expected=%h", m_tag, m_act, m_exp);
        end
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset values
    expect_reg(R_CTRL, 32'h0, "R1 ctrl");
    expect_reg(R_TOP, 32'h0000FFFF, "R1 top");
    expect_reg(R_CNT, 32'h0, "R1 cnt");
    expect_reg(R_IEN, 32'h0, "R1 ien");
    expect_reg(R_FLAG, 32'h0, "R1 flags");
    expect_irq(1'b0, "R1 irq");

    // R2 readback and field masking
    wr(R_CTRL, 32'hFFFF_FFFF);
    expect_reg(R_CTRL, 32'h0F03_0013, "R2 ctrl mask");
    wr(R_TOP, 32'h1234_ABCD);
    expect_reg(R_TOP, 32'h0000_ABCD, "R2 top");
    expect_reg(R_CMD, 32'h0, "R2 cmd reads 0");
    wr(R_TOP, 32'h0000_FFFF);
    wr(R_CTRL, 32'h0);

    // R4 up-count, no prescale
    wr(R_CNT, 32'h0);
    wr(R_CMD, 32'h1);
    idle(7);
    expect_reg(R_CNT, up_expect(0, 7, 0, 16'hFFFF), "R4 up p0");

    // R4 divide by 8, then R3 stop holds
    wr(R_CMD, 32'h2);
    wr(R_CNT, 32'h0);
    wr(R_CTRL, 32'h0300_0000);
    wr(R_CMD, 32'h1);
    idle(20);
    expect_reg(R_CNT, up_expect(0, 20, 3, 16'hFFFF), "R4 up p3");
    wr(R_CMD, 32'h2);
    expect_reg(R_CNT, 32'd2, "R3 after stop");
    idle(10);
    expect_reg(R_CNT, 32'd2, "R3 stopped holds");

    // R4 start restarts the prescaler phase (divide by 4)
    wr(R_CNT, 32'h0);
    wr(R_CTRL, 32'h0200_0000);
    wr(R_CMD, 32'h1);
    idle(5);
    expect_reg(R_CNT, 32'd1, "R4 p2 first step");
    wr(R_CMD, 32'h2);
    wr(R_CMD, 32'h1);
    idle(3);
    expect_reg(R_CNT, 32'd1, "R4 restart no early step");
    expect_reg(R_CNT, 32'd2, "R4 restart step after 4");
    wr(R_CMD, 32'h2);

    // R5 up wrap at top, flag bit 0
    wr(R_FCLR, 32'h3);
    wr(R_TOP, 32'd5);
    wr(R_CNT, 32'd3);
    wr(R_CTRL, 32'h0);
    wr(R_CMD, 32'h1);
    idle(4);
    expect_reg(R_CNT, 32'd1, "R5 wrap count");
    expect_reg(R_FLAG, 32'h1, "R5 ovf flag");
    wr(R_CMD, 32'h2);

    // R6 periodic down-count
    wr(R_FCLR, 32'h3);
    wr(R_TOP, 32'd4);
    wr(R_CNT, 32'd2);
    wr(R_CTRL, 32'h1);
    wr(R_CMD, 32'h1);
    idle(3);
    expect_reg(R_CNT, 32'd4, "R6 reload top");
    expect_reg(R_FLAG, 32'h2, "R6 unf flag");
    expect_reg(R_CNT, 32'd2, "R6 keeps running");
    wr(R_CMD, 32'h2);

    // R7 one-shot down-count; R10 load
    wr(R_FCLR, 32'h3);
    wr(R_CNT, 32'd2);
    wr(R_CTRL, 32'h11);
    wr(R_CMD, 32'h1);
    idle(3);
    expect_reg(R_CNT, 32'd0, "R7 stays zero");
    expect_reg(R_FLAG, 32'h2, "R7 unf flag");
    idle(10);
    expect_reg(R_CNT, 32'd0, "R7 halted");
    wr(R_CNT, 32'd5);
    idle(5);
    expect_reg(R_CNT, 32'd5, "R10 load while halted R7");

    // R8 / R9 flag registers and interrupt masking
    wr(R_IEN, 32'h2);
    expect_irq(1'b1, "R9 unf enabled");
    wr(R_FCLR, 32'h2);
    expect_reg(R_FLAG, 32'h0, "R8 clear");
    expect_irq(1'b0, "R9 no flags");
    wr(R_FSET, 32'h1);
    expect_reg(R_FLAG, 32'h1, "R8 set");
    expect_irq(1'b0, "R9 ovf masked");
    wr(R_IEN, 32'h3);
    expect_irq(1'b1, "R9 ovf enabled");
    expect_reg(R_IEN, 32'h3, "R2 ien");
    wr(R_FSET, 32'h2);
    expect_reg(R_FLAG, 32'h3, "R8 set both");

    // R8 hardware set beats software clear
    wr(R_IEN, 32'h0);
    wr(R_FCLR, 32'h3);
    wr(R_TOP, 32'd9);
    wr(R_CNT, 32'd0);
    wr(R_CTRL, 32'h1);
    wr(R_CMD, 32'h1);
    wr(R_FCLR, 32'h2);
    expect_reg(R_FLAG, 32'h2, "R8 set wins");
    expect_reg(R_CNT, 32'd8, "R6 reload then step");
    wr(R_FCLR, 32'h2);
    expect_reg(R_FLAG, 32'h0, "R8 clear alone");
    expect_irq(1'b0, "R9 mask zero");
    wr(R_CMD, 32'h2);

    @(negedge clk);
    #2;
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
    $finish;
  end
endmodule